// File: doc/BRIEF.md
# Bus Write-Busy Status Timer

This block produces an 8-bit status value for a peripheral expansion bus. The status tells software whether recent bus word writes are still in flight. Each write strobe starts or stretches time windows for three status bits, and each bit follows its own rule. Time is counted by a free-running 32-bit tick counter that advances once per clock and is cleared by reset. Counter rollover is not modelled.

Bit 5 is a plain "recently written" flag. It goes high after every write and drops a fixed eight ticks after the latest one. Bit 4 rises a short delay after a write that finds it idle. Every further write adds more busy time to its fall, so a burst of writes stacks up. Bit 0 rises a longer delay after a write that finds it idle and falls a fixed time later. A write that arrives while bit 0 is still in its window only pushes the fall later.

For bits 4 and 0, a bit whose fall time has been reached reads 0. A bit whose rise time alone has been reached reads 1. A bit that has reached neither keeps the value it had on the previous cycle. Bits 3, 2 and 1 are tied to 1 and bits 7 and 6 to 0. The status output is combinational on the timer state, so a write is visible on the cycle after its strobe.

Top module: `bus_busy_status`

## Requirements
- R1: After synchronous reset the tick counter and every rise and fall time are zero. With no writes, the status reads 0x0E.
- R2: Status bits 7 and 6 always read 0 and bits 3, 2 and 1 always read 1. Bits 5, 4 and 0 sit at those positions.
- R3: A write strobe in the cycle with tick t makes bit 5 read 1 from the next cycle. Bit 5 reads 0 from tick t+8 onward unless a later write restarts it.
- R4: A write at tick t that finds bit 4's fall time strictly earlier than t sets bit 4's rise to t+8 and its fall to t+16.
- R5: A write at tick t that finds bit 4's fall time at or after t moves that fall time 16 ticks later and leaves the rise time alone, so back-to-back writes add up.
- R6: A write at tick t that finds bit 0's fall time strictly earlier than t sets bit 0's rise to t+24 and its fall to t+48.
- R7: A write that finds bit 0's fall time at or after the current tick adds 24 ticks to that fall time and leaves the rise time alone.
- R8: For bits 4 and 0, a time equal to the current tick counts as reached. A reached fall time forces the bit to 0 even when the rise time is also reached. If only the rise time is reached the bit reads 1. Otherwise the bit holds its previous-cycle value.
- R9: A write that lands exactly on a bit's fall tick counts as "not yet passed" for the restart decision (R5 and R7 apply, not R4 and R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | One-cycle strobe marking one bus word write |
| status_o | output | 8 | Status value: bit 5 recent-write, bit 4 and bit 0 busy windows, bits 3..1 fixed at 1 |

## Verification
The bench mirrors the timer rules in a reference model and compares it with the status on every cycle. A strobe at tick t shows on bit 5 one cycle later and clears bit 5 at tick t+8. From an idle state, the same strobe makes bit 4 read 1 at tick t+8 and 0 at t+16, and bit 0 read 1 at t+24 and 0 at t+48. Strobes are driven and the status is sampled on the falling clock edge, after the tick counter has settled to the tick being compared. The stimulus runs through these phases:
- an idle period after reset
- a lone write
- a back-to-back burst
- a write placed on the exact fall tick of bit 4
- a long random stretch
Each phase tags its comparisons with the requirement it targets.

// File: rtl/bus_busy_pkg.sv
package bus_busy_pkg;

    localparam int TICK_W = 32;

    typedef logic [TICK_W-1:0] tick_t;

    // How a write that lands inside an open window changes it
    typedef enum logic {
        RULE_ACCUM = 1'b0,  // fall = max(now, fall) + hold, rise kept
        RULE_CHAIN = 1'b1   // fall += hold, rise kept
    } ext_rule_e;

    typedef struct packed {
        tick_t rise_t;
        tick_t fall_t;
    } window_t;

    typedef struct packed {
        logic [1:0] zeros;
        logic       recent;
        logic       busy_mid;
        logic [2:0] ones;
        logic       busy_low;
    } status_t;

    localparam logic [2:0] FIXED_ONES = 3'b111;

    // A scheduled time counts as reached once the tick has arrived at it
    function automatic logic is_reached(input tick_t when, input tick_t now);
        return when <= now;
    endfunction

    // A scheduled time counts as passed only when strictly behind the tick
    function automatic logic is_passed(input tick_t when, input tick_t now);
        return when < now;
    endfunction

    function automatic tick_t tick_max(input tick_t a, input tick_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wbs_tick_counter.sv
module wbs_tick_counter
    import bus_busy_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_t tick_o
);

    tick_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + tick_t'(1);
    end

    assign tick_o = cnt_q;

    a_r1_tick_advances: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + tick_t'(1));

endmodule

// File: rtl/wbs_hold_timer.sv
module wbs_hold_timer
    import bus_busy_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  tick_t now_i,
    output logic  bit_o
);

    localparam tick_t HOLD_T = tick_t'(HOLD);

    tick_t fall_q;
    logic  flag_q;
    logic  flag_now;

    always_comb begin
        flag_now = is_reached(fall_q, now_i) ? 1'b0 : flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_q <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= wr_i ? 1'b1 : flag_now;
            if (wr_i) fall_q <= now_i + HOLD_T;
        end
    end

    assign bit_o = flag_now;

    // R3: the flag is up on the cycle after any strobe
    a_r3_set_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> bit_o);

    // R3: the drop time only moves on a write
    a_r3_fall_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(fall_q));

endmodule

// File: rtl/wbs_window_timer.sv
module wbs_window_timer
    import bus_busy_pkg::*;
#(
    parameter ext_rule_e RULE = RULE_ACCUM,
    parameter int        RISE = 8,
    parameter int        HOLD = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  tick_t now_i,
    output logic  bit_o
);

    localparam tick_t RISE_T = tick_t'(RISE);
    localparam tick_t HOLD_T = tick_t'(HOLD);

    window_t win_q, win_d;
    logic    held_q;
    logic    bit_now;
    logic    idle;

    always_comb begin
        idle = is_passed(win_q.fall_t, now_i);
        if (is_reached(win_q.fall_t, now_i))      bit_now = 1'b0;
        else if (is_reached(win_q.rise_t, now_i)) bit_now = 1'b1;
        else                                      bit_now = held_q;
    end

    generate
        if (RULE == RULE_ACCUM) begin : g_accum
            always_comb begin
                win_d = win_q;
                if (wr_i) begin
                    if (idle) win_d.rise_t = now_i + RISE_T;
                    win_d.fall_t = tick_max(now_i, win_q.fall_t) + HOLD_T;
                end
            end
        end else begin : g_chain
            always_comb begin
                win_d = win_q;
                if (wr_i) begin
                    if (idle) begin
                        win_d.rise_t = now_i + RISE_T;
                        win_d.fall_t = now_i + RISE_T + HOLD_T;
                    end else begin
                        win_d.fall_t = win_q.fall_t + HOLD_T;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            held_q <= 1'b0;
        end else begin
            win_q  <= win_d;
            held_q <= bit_now;
        end
    end

    assign bit_o = bit_now;

    // R5 / R7: a write always pushes the fall time later
    a_r5_fall_grows: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> win_q.fall_t > $past(win_q.fall_t));

    // R4 / R6: a restarting write schedules the rise in the future
    a_r4_rise_ahead: assert property (@(posedge clk) disable iff (rst)
        wr_i && idle |=> win_q.rise_t > $past(now_i));

    // R7 / R9: a write into an open window leaves the rise untouched
    a_r7_rise_kept: assert property (@(posedge clk) disable iff (rst)
        wr_i && !idle |=> $stable(win_q.rise_t));

    // R8: without a write the window is frozen
    a_r8_window_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(win_q));

endmodule

// File: rtl/wbs_status_pack.sv
module wbs_status_pack
    import bus_busy_pkg::*;
(
    input  logic       recent_i,
    input  logic       busy_mid_i,
    input  logic       busy_low_i,
    output logic [7:0] status_o
);

    status_t st;

    always_comb begin
        st.zeros    = 2'b00;
        st.recent   = recent_i;
        st.busy_mid = busy_mid_i;
        st.ones     = FIXED_ONES;
        st.busy_low = busy_low_i;
    end

    assign status_o = st;

endmodule

// File: rtl/bus_busy_status.sv
module bus_busy_status
    import bus_busy_pkg::*;
#(
    parameter int RECENT_HOLD = 8,
    parameter int MID_RISE    = 8,
    parameter int MID_HOLD    = 16,
    parameter int LOW_RISE    = 24,
    parameter int LOW_HOLD    = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    output logic [7:0] status_o
);

    localparam int NWIN = 2;  // index 0: bit 4 window, index 1: bit 0 window

    tick_t          now;
    logic           recent;
    logic [NWIN-1:0] win_bits;

    wbs_tick_counter u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (now)
    );

    wbs_hold_timer #(.HOLD(RECENT_HOLD)) u_recent (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (wr_i),
        .now_i (now),
        .bit_o (recent)
    );

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            localparam ext_rule_e G_RULE = (g == 0) ? RULE_ACCUM : RULE_CHAIN;
            localparam int        G_RISE = (g == 0) ? MID_RISE : LOW_RISE;
            localparam int        G_HOLD = (g == 0) ? MID_HOLD : LOW_HOLD;
            wbs_window_timer #(
                .RULE (G_RULE),
                .RISE (G_RISE),
                .HOLD (G_HOLD)
            ) u_win (
                .clk   (clk),
                .rst   (rst),
                .wr_i  (wr_i),
                .now_i (now),
                .bit_o (win_bits[g])
            );
        end
    endgenerate

    wbs_status_pack u_pack (
        .recent_i   (recent),
        .busy_mid_i (win_bits[0]),
        .busy_low_i (win_bits[1]),
        .status_o   (status_o)
    );

    // R1: leaving reset shows only the fixed bits
    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> status_o == 8'h0E);

    // R3: a write shows on bit 5 next cycle
    a_r3_recent_bit: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> status_o[5]);

endmodule

// File: tb/sim_bus_busy_status.sv
`timescale 1ns/1ps
module sim_bus_busy_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr  = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    string tag_fix  = "R1";
    string tag_rec  = "R1";
    string tag_mid  = "R1";
    string tag_low  = "R1";

    always #4 clk = ~clk;

    bus_busy_status u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr),
        .status_o (status)
    );

    // Behavioural reference model
    longint m_tick, m_rec_fall, m_mid_rise, m_mid_fall, m_low_rise, m_low_fall;
    bit     m_rec, m_mid, m_low;

    function automatic bit exp_rec();
        return (m_rec_fall <= m_tick) ? 1'b0 : m_rec;
    endfunction
    function automatic bit exp_win(longint rise, longint fall, bit held);
        if (fall <= m_tick) return 1'b0;
        if (rise <= m_tick) return 1'b1;
        return held;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tick = 0; m_rec_fall = 0; m_mid_rise = 0; m_mid_fall = 0;
            m_low_rise = 0; m_low_fall = 0; m_rec = 0; m_mid = 0; m_low = 0;
        end else begin
            bit r, a, b;
            r = exp_rec();
            a = exp_win(m_mid_rise, m_mid_fall, m_mid);
            b = exp_win(m_low_rise, m_low_fall, m_low);
            m_rec = wr ? 1'b1 : r;
            m_mid = a;
            m_low = b;
            if (wr) begin
                m_rec_fall = m_tick + 8;
                if (m_mid_fall < m_tick) m_mid_rise = m_tick + 8;
                m_mid_fall = ((m_mid_fall > m_tick) ? m_mid_fall : m_tick) + 16;
                if (m_low_fall < m_tick) begin
                    m_low_rise = m_tick + 24;
                    m_low_fall = m_tick + 48;
                end else begin
                    m_low_fall = m_low_fall + 24;
                end
            end
            m_tick = m_tick + 1;
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s tick=%0d actual=%b expected=%b", req, what, m_tick, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (status[7:6] !== 2'b00 || status[3:1] !== 3'b111) begin
                errors++;
                $display("FAIL %s fixed bits actual=%b expected=00xx111x", tag_fix, status);
            end
            check_bit(tag_rec, "bit5", status[5], exp_rec());
            check_bit(tag_mid, "bit4", status[4], exp_win(m_mid_rise, m_mid_fall, m_mid));
            check_bit(tag_low, "bit0", status[0], exp_win(m_low_rise, m_low_fall, m_low));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr = 1'b0;
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: exact reset value right after release
        @(negedge clk);
        checks++;
        if (status !== 8'h0E) begin
            errors++;
            $display("FAIL R1 reset status actual=%h expected=0e", status);
        end
        idle(20);

        // Lone write: R3 bit 5, R4 bit 4, R6 bit 0, R8 hold/priority, R2 fixed
        tag_fix = "R2"; tag_rec = "R3"; tag_mid = "R4"; tag_low = "R6";
        strobe();
        idle(70);

        // Back-to-back burst: R5 accumulation, R7 extension
        tag_mid = "R5"; tag_low = "R7";
        strobe(); strobe(); strobe();
        @(negedge clk); wr = 1'b1;
        @(negedge clk); wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        idle(150);

        // Write landing exactly on bit 4's fall tick: R9
        tag_mid = "R9"; tag_low = "R9";
        @(negedge clk); wr = 1'b1;        // write at tick t
        @(negedge clk); wr = 1'b0;
        idle(14);                          // next strobe sits at tick t+16
        @(negedge clk); wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        idle(100);

        // Random stretch: R8 hold and off-priority across many patterns
        tag_rec = "R3"; tag_mid = "R8"; tag_low = "R8";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            wr = ($urandom_range(0, 5) == 0);
        end
        @(negedge clk); wr = 1'b0;
        idle(120);
        finish_run();
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule